// File: doc/BRIEF.md
# NIC FIFO Watermark Interrupt Controller

This block raises one level-sensitive interrupt line for a network interface that has separate receive and transmit FIFOs. It takes the current occupancy of each FIFO, a pulse for each received packet, and a completion pulse from each DMA direction. From these it builds a set of status bits, and those bits pass through a mask to the interrupt output. The watermark events use hysteresis. The receive side must drain to empty before filling past its mark can interrupt. The transmit side must fill completely before draining to its mark can interrupt. Each such record is consumed when the mark is crossed.

A register port (one-cycle write strobe, one-cycle read strobe, combinational read data) gives software several things. It holds the marks, the mask and a per-interrupt packet cap. It gives read-only FIFO sizes and a status register that clears when read. Two data-doorbell addresses mark a DMA direction busy until that direction reports completion. A command register has a bit that returns the block to its default state.

Register map (4-bit address): 0 command, 1 status, 2 mask, 3 receive mark, 4 transmit mark, 5 receive FIFO size, 6 transmit FIFO size, 7 receive doorbell, 8 transmit doorbell, 9 packet cap. Status and mask bits: 0 receive-high, 1 transmit-low, 2 packet cap reached, 3 receive DMA done, 4 transmit DMA done.

Top module: `nic_irq_ctrl`

## Requirements
- R1: After reset, status (addr 1), mask (addr 2) and irq are 0. The receive mark (addr 3) reads 48, the transmit mark (addr 4) reads 16 and the packet cap (addr 9) reads 4.
- R2: Status bit 0 sets when the receive level is at or above the receive mark, but only if the receive level has been 0 since that bit's last firing. Without that prior empty, crossing the mark sets nothing.
- R3: Status bit 1 sets when the transmit level is at or below the transmit mark, but only if the transmit level has equalled the FIFO depth (64) since that bit's last firing.
- R4: The empty and full records are cleared when the corresponding bit fires. A second crossing without a new empty (receive) or full (transmit) does not set the bit again.
- R5: A read of addr 1 returns the pending status bits and clears them at that clock edge.
- R6: A status event that occurs in the same cycle as a clearing read of addr 1 remains pending afterwards.
- R7: irq is high exactly when some status bit is set whose mask bit is also set.
- R8: rx_pkt pulses are counted from the last status read. When the count reaches the packet cap, status bit 2 sets. A cap of 0 disables this event.
- R9: Writing addr 7 (receive) or addr 8 (transmit) sets that direction's busy flag, which reads as bit 0 of the same address. The matching DMA-done pulse clears the flag and sets status bit 3 (receive) or bit 4 (transmit).
- R10: Writing addr 0 with bit 0 set restores the defaults of R1. It also clears both busy flags and the empty/full records, so a later crossing of a mark sets nothing until a new empty or full occurs.
- R11: Addrs 5 and 6 read the FIFO depths (64 each), and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_level | input | 7 | Receive FIFO occupancy |
| tx_level | input | 7 | Transmit FIFO occupancy |
| rx_pkt | input | 1 | One-cycle pulse per received packet |
| rx_dma_done | input | 1 | Receive DMA completion pulse |
| tx_dma_done | input | 1 | Transmit DMA completion pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the strobe cycle |
| irq | output | 1 | Masked interrupt request, level |

## Verification
A stale empty or full record is not visible at once. It shows up at the next crossing of the mark, as a status bit that is either missing or extra, readable one cycle after the level moves. A wrong packet count shows on irq in the cycle after the pulse that should reach the cap. A lost or premature clear of status shows on the very next read of addr 1.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
   localparam int ADDR_W = 4;

   typedef enum logic [ADDR_W-1:0] {
      A_CMD    = 4'd0,
      A_STAT   = 4'd1,
      A_MASK   = 4'd2,
      A_RXMARK = 4'd3,
      A_TXMARK = 4'd4,
      A_RXSIZE = 4'd5,
      A_TXSIZE = 4'd6,
      A_RXDATA = 4'd7,
      A_TXDATA = 4'd8,
      A_PKTMAX = 4'd9
   } reg_addr_e;

   localparam int ST_RXHIGH = 0;
   localparam int ST_TXLOW  = 1;
   localparam int ST_RXPKT  = 2;
   localparam int ST_RXDMA  = 3;
   localparam int ST_TXDMA  = 4;
   localparam int NUM_ST    = 5;
endpackage

// File: rtl/nic_wm_track.sv
module nic_wm_track #(
   parameter int DEPTH        = 64,
   parameter bit ARM_ON_EMPTY = 1'b1,
   localparam int LW          = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic [LW-1:0] level,
   input  logic [LW-1:0] mark,
   output logic          armed,
   output logic          fire
);
   logic arm_hit;
   logic crossed;

   generate
      if (ARM_ON_EMPTY) begin : g_fill
         // arm on empty, fire when filling reaches the mark
         assign arm_hit = (level == '0);
         assign crossed = (level >= mark);
      end else begin : g_drain
         // arm on full, fire when draining reaches the mark
         assign arm_hit = (level == LW'(DEPTH));
         assign crossed = (level <= mark);
      end
   endgenerate

   assign fire = armed && crossed && !arm_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       armed <= 1'b0;
      else if (clr)     armed <= 1'b0;
      else if (arm_hit) armed <= 1'b1;
      else if (fire)    armed <= 1'b0;
   end
endmodule

// File: rtl/nic_pkt_cap.sv
module nic_pkt_cap #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             pkt,
   input  logic [CNT_W-1:0] cap,
   output logic [CNT_W-1:0] cnt,
   output logic             hit
);
   logic       enabled;
   logic       room;
   logic [CNT_W:0] next_cnt;

   assign enabled  = (cap != '0);
   assign room     = (cnt < cap);
   assign next_cnt = {1'b0, cnt} + 1'b1;
   assign hit      = pkt && enabled && room && (next_cnt == {1'b0, cap});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt <= '0;
      else if (clr)                     cnt <= '0;
      else if (pkt && enabled && room)  cnt <= next_cnt[CNT_W-1:0];
   end
endmodule

// File: rtl/nic_irq_ctrl.sv
module nic_irq_ctrl
   import nic_irq_pkg::*;
#(
   parameter int RX_DEPTH    = 64,
   parameter int TX_DEPTH    = 64,
   parameter int DATA_W      = 32,
   parameter int CNT_W       = 8,
   parameter int RX_MARK_DEF = 48,
   parameter int TX_MARK_DEF = 16,
   parameter int PKTMAX_DEF  = 4,
   localparam int RLW        = $clog2(RX_DEPTH + 1),
   localparam int TLW        = $clog2(TX_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RLW-1:0]    rx_level,
   input  logic [TLW-1:0]    tx_level,
   input  logic              rx_pkt,
   input  logic              rx_dma_done,
   input  logic              tx_dma_done,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   generate
      if (RX_MARK_DEF > RX_DEPTH || TX_MARK_DEF > TX_DEPTH) begin : g_bad_mark
         $error("nic_irq_ctrl: default mark exceeds FIFO depth");
      end
      if (DATA_W < NUM_ST || DATA_W < CNT_W || DATA_W < RLW || DATA_W < TLW) begin : g_bad_dw
         $error("nic_irq_ctrl: DATA_W too narrow");
      end
      if (PKTMAX_DEF >= (1 << CNT_W)) begin : g_bad_cap
         $error("nic_irq_ctrl: PKTMAX_DEF does not fit CNT_W");
      end
   endgenerate

   logic              soft_rst, rd_stat;
   logic              wr_mask, wr_rxmark, wr_txmark, wr_pktmax, wr_rxdata, wr_txdata;
   logic [NUM_ST-1:0] status, mask, st_set;
   logic [RLW-1:0]    rx_mark;
   logic [TLW-1:0]    tx_mark;
   logic [CNT_W-1:0]  pkt_max, pkt_cnt;
   logic              rx_armed, tx_armed, rx_fire, tx_fire, pkt_hit;
   logic              rx_busy, tx_busy;

   assign soft_rst  = reg_wr && (reg_addr == A_CMD) && reg_wdata[0];
   assign rd_stat   = reg_rd && (reg_addr == A_STAT);
   assign wr_mask   = reg_wr && (reg_addr == A_MASK);
   assign wr_rxmark = reg_wr && (reg_addr == A_RXMARK);
   assign wr_txmark = reg_wr && (reg_addr == A_TXMARK);
   assign wr_pktmax = reg_wr && (reg_addr == A_PKTMAX);
   assign wr_rxdata = reg_wr && (reg_addr == A_RXDATA);
   assign wr_txdata = reg_wr && (reg_addr == A_TXDATA);

   nic_wm_track #(.DEPTH(RX_DEPTH), .ARM_ON_EMPTY(1'b1)) u_rx_wm (
      .clk(clk), .rst_n(rst_n), .clr(soft_rst),
      .level(rx_level), .mark(rx_mark), .armed(rx_armed), .fire(rx_fire)
   );

   nic_wm_track #(.DEPTH(TX_DEPTH), .ARM_ON_EMPTY(1'b0)) u_tx_wm (
      .clk(clk), .rst_n(rst_n), .clr(soft_rst),
      .level(tx_level), .mark(tx_mark), .armed(tx_armed), .fire(tx_fire)
   );

   nic_pkt_cap #(.CNT_W(CNT_W)) u_pkt (
      .clk(clk), .rst_n(rst_n), .clr(soft_rst || rd_stat || wr_pktmax),
      .pkt(rx_pkt), .cap(pkt_max), .cnt(pkt_cnt), .hit(pkt_hit)
   );

   always_comb begin
      st_set            = '0;
      st_set[ST_RXHIGH] = rx_fire;
      st_set[ST_TXLOW]  = tx_fire;
      st_set[ST_RXPKT]  = pkt_hit;
      st_set[ST_RXDMA]  = rx_dma_done;
      st_set[ST_TXDMA]  = tx_dma_done;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status  <= '0;
         mask    <= '0;
         rx_mark <= RLW'(RX_MARK_DEF);
         tx_mark <= TLW'(TX_MARK_DEF);
         pkt_max <= CNT_W'(PKTMAX_DEF);
         rx_busy <= 1'b0;
         tx_busy <= 1'b0;
      end else if (soft_rst) begin
         status  <= '0;
         mask    <= '0;
         rx_mark <= RLW'(RX_MARK_DEF);
         tx_mark <= TLW'(TX_MARK_DEF);
         pkt_max <= CNT_W'(PKTMAX_DEF);
         rx_busy <= 1'b0;
         tx_busy <= 1'b0;
      end else begin
         status <= (rd_stat ? '0 : status) | st_set;
         if (wr_mask)   mask    <= reg_wdata[NUM_ST-1:0];
         if (wr_rxmark) rx_mark <= reg_wdata[RLW-1:0];
         if (wr_txmark) tx_mark <= reg_wdata[TLW-1:0];
         if (wr_pktmax) pkt_max <= reg_wdata[CNT_W-1:0];
         if (wr_rxdata)        rx_busy <= 1'b1;
         else if (rx_dma_done) rx_busy <= 1'b0;
         if (wr_txdata)        tx_busy <= 1'b1;
         else if (tx_dma_done) tx_busy <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_STAT:   reg_rdata = DATA_W'(status);
         A_MASK:   reg_rdata = DATA_W'(mask);
         A_RXMARK: reg_rdata = DATA_W'(rx_mark);
         A_TXMARK: reg_rdata = DATA_W'(tx_mark);
         A_RXSIZE: reg_rdata = DATA_W'(RX_DEPTH);
         A_TXSIZE: reg_rdata = DATA_W'(TX_DEPTH);
         A_RXDATA: reg_rdata = DATA_W'(rx_busy);
         A_TXDATA: reg_rdata = DATA_W'(tx_busy);
         A_PKTMAX: reg_rdata = DATA_W'(pkt_max);
         default:  reg_rdata = '0;
      endcase
   end

   assign irq = |(status & mask);
endmodule

// File: rtl/nic_irq_ctrl_chk.sv
module nic_irq_ctrl_chk
   import nic_irq_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [NUM_ST-1:0] status,
   input logic [NUM_ST-1:0] mask,
   input logic              rx_armed,
   input logic              tx_armed,
   input logic              rx_fire,
   input logic              rx_busy,
   input logic [CNT_W-1:0]  pkt_cnt,
   input logic [CNT_W-1:0]  pkt_max
);
   // R2
   rxh_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status[ST_RXHIGH] && !$past(status[ST_RXHIGH])) |-> $past(rx_armed));

   // R3
   txl_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status[ST_TXLOW] && !$past(status[ST_TXLOW])) |-> $past(tx_armed));

   // R6
   keep_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_fire && reg_rd && reg_addr == A_STAT) |=> status[ST_RXHIGH]);

   // R10
   soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_CMD && reg_wdata[0])
         |=> (status == '0 && mask == '0 && !rx_armed && !tx_armed && !rx_busy));

   // R9
   busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_RXDATA) |=> rx_busy);

   // R8
   pkt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_max != '0) |-> (pkt_cnt <= pkt_max));
endmodule

bind nic_irq_ctrl nic_irq_ctrl_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .status(status), .mask(mask),
   .rx_armed(rx_armed), .tx_armed(tx_armed), .rx_fire(rx_fire),
   .rx_busy(rx_busy), .pkt_cnt(pkt_cnt), .pkt_max(pkt_max)
);

// File: tb/nic_irq_ctrl_tb.sv
module nic_irq_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  rx_level = 7'd10;
   logic [6:0]  tx_level = 7'd30;
   logic        rx_pkt = 1'b0, rx_dma_done = 1'b0, tx_dma_done = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   nic_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .tx_level(tx_level),
      .rx_pkt(rx_pkt), .rx_dma_done(rx_dma_done), .tx_dma_done(tx_dma_done),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] v);
      @(negedge clk); reg_rd = 1'b1; reg_addr = a;
      #1 v = reg_rdata;
      @(negedge clk); reg_rd = 1'b0;
   endtask

   task automatic rx_to(input logic [6:0] v);
      @(negedge clk); rx_level = v;
      repeat (2) @(negedge clk);
   endtask

   task automatic tx_to(input logic [6:0] v);
      @(negedge clk); tx_level = v;
      repeat (2) @(negedge clk);
   endtask

   task automatic pkt_pulse();
      @(negedge clk); rx_pkt = 1'b1;
      @(negedge clk); rx_pkt = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(4'd1, v); chk("R1 status", v, 0);
      rd(4'd2, v); chk("R1 mask", v, 0);
      rd(4'd3, v); chk("R1 rx mark", v, 48);
      rd(4'd4, v); chk("R1 tx mark", v, 16);
      rd(4'd9, v); chk("R1 pkt cap", v, 4);
      chk("R1 irq", {31'd0, irq}, 0);
   endtask

   task automatic t_sizes();
      logic [31:0] v;
      rd(4'd5, v); chk("R11 rx size", v, 64);
      rd(4'd6, v); chk("R11 tx size", v, 64);
      wr(4'd5, 32'd3);
      wr(4'd6, 32'd7);
      rd(4'd5, v); chk("R11 rx size after write", v, 64);
      rd(4'd6, v); chk("R11 tx size after write", v, 64);
   endtask

   task automatic t_rx_gate();
      logic [31:0] v;
      rx_to(7'd50);
      rd(4'd1, v); chk("R2 no fire without empty", v, 0);
      rx_to(7'd0); rx_to(7'd50);
      rd(4'd1, v); chk("R2 fire after empty", v, 1);
      rd(4'd1, v); chk("R5 cleared by read", v, 0);
      rx_to(7'd20); rx_to(7'd50);
      rd(4'd1, v); chk("R4 rx no refire", v, 0);
      rx_to(7'd10);
   endtask

   task automatic t_tx_gate();
      logic [31:0] v;
      tx_to(7'd10);
      rd(4'd1, v); chk("R3 no fire without full", v, 0);
      tx_to(7'd64); tx_to(7'd10);
      rd(4'd1, v); chk("R3 fire after full", v, 2);
      tx_to(7'd30); tx_to(7'd10);
      rd(4'd1, v); chk("R4 tx no refire", v, 0);
      tx_to(7'd30);
   endtask

   task automatic t_irq_mask();
      logic [31:0] v;
      wr(4'd2, 32'd2);
      rx_to(7'd0); rx_to(7'd50);
      chk("R7 masked bit gives no irq", {31'd0, irq}, 0);
      rd(4'd1, v); chk("R7 status under mask", v, 1);
      rx_to(7'd10);
      tx_to(7'd64); tx_to(7'd10);
      chk("R7 unmasked bit raises irq", {31'd0, irq}, 1);
      rd(4'd1, v); chk("R7 status", v, 2);
      chk("R7 irq drops after clear", {31'd0, irq}, 0);
      tx_to(7'd30);
   endtask

   task automatic t_pkt_cap();
      logic [31:0] v;
      wr(4'd2, 32'd4);
      wr(4'd9, 32'd3);
      pkt_pulse(); pkt_pulse();
      chk("R8 below cap", {31'd0, irq}, 0);
      pkt_pulse();
      chk("R8 cap reached", {31'd0, irq}, 1);
      rd(4'd1, v); chk("R8 status", v, 4);
      wr(4'd9, 32'd0);
      for (int i = 0; i < 5; i++) pkt_pulse();
      chk("R8 cap zero irq", {31'd0, irq}, 0);
      rd(4'd1, v); chk("R8 cap zero status", v, 0);
      wr(4'd9, 32'd4);
   endtask

   task automatic t_busy();
      logic [31:0] v;
      wr(4'd7, 32'd0);
      rd(4'd7, v); chk("R9 rx busy set", v, 1);
      @(negedge clk); rx_dma_done = 1'b1;
      @(negedge clk); rx_dma_done = 1'b0;
      rd(4'd7, v); chk("R9 rx busy cleared", v, 0);
      rd(4'd1, v); chk("R9 rx done status", v, 8);
      wr(4'd8, 32'd0);
      rd(4'd8, v); chk("R9 tx busy set", v, 1);
      @(negedge clk); tx_dma_done = 1'b1;
      @(negedge clk); tx_dma_done = 1'b0;
      rd(4'd8, v); chk("R9 tx busy cleared", v, 0);
      rd(4'd1, v); chk("R9 tx done status", v, 16);
   endtask

   task automatic t_coincide();
      logic [31:0] v;
      rx_to(7'd0);
      @(negedge clk); rx_level = 7'd50; reg_rd = 1'b1; reg_addr = 4'd1;
      #1 v = reg_rdata;
      chk("R6 read before event", v, 0);
      @(negedge clk); reg_rd = 1'b0;
      rd(4'd1, v); chk("R6 event kept", v, 1);
      rx_to(7'd10);
   endtask

   task automatic t_soft_reset();
      logic [31:0] v;
      wr(4'd2, 32'd5);
      wr(4'd3, 32'd20);
      wr(4'd7, 32'd0);
      rx_to(7'd0); rx_to(7'd10);
      wr(4'd0, 32'd1);
      rd(4'd2, v); chk("R10 mask default", v, 0);
      rd(4'd3, v); chk("R10 rx mark default", v, 48);
      rd(4'd7, v); chk("R10 busy cleared", v, 0);
      rx_to(7'd50);
      rd(4'd1, v); chk("R10 armed record cleared", v, 0);
      rx_to(7'd10);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sizes();
      t_rx_gate();
      t_tx_gate();
      t_irq_mask();
      t_pkt_cap();
      t_busy();
      t_coincide();
      t_soft_reset();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule